// File: doc/BRIEF.md
# Single-Wire Slave Time-Slot Engine

This block is the bit-level engine of a slave on a single-wire, open-drain, bidirectional bus. It runs on the system clock and watches a line input that has already been synchronized and thresholded. It drives one pulldown enable that an open-drain pad turns into a low on the wire. The host starts every bit by pulling the line low. The engine finds that falling edge, times the slot from it, and samples the line at a fixed point. The sampled level is reported as a received bit with a one-cycle strobe.

When the layer above has a bit ready, the engine offers it in the same slot. A zero is sent by holding the line low past the sampling point until an internal timer ends. A one is sent by leaving the line alone. At standard speed, the falling edge must stay low for a minimum width before it counts, so short noise is rejected. At overdrive speed this filter is bypassed. After each slot the engine waits for the line to return high. It then ignores any low excursion for a hold-off window, so ringing on the rising edge cannot start a false slot. A speed-select input picks one of two parameter sets, and it is only sampled between slots.

Top module: `sw_slot_engine`

## Requirements
- R1: While `rst_n` is low, and in the idle state after it, `pull_o`, `rx_valid_o` and `tx_take_o` are 0.
- R2: At standard speed a slot starts only after `line_i` has been sampled low on FLT_STD consecutive clock edges, counting the first low sample as 1. A shorter low produces no strobe, no take and no pulldown. A low of exactly FLT_STD samples does start a slot.
- R3: At overdrive speed the first low sample starts the slot, with no width filter.
- R4: The engine samples `line_i` at the edge that comes SAMP cycles after the first low sample (SAMP_STD or SAMP_OD). In the following cycle `rx_valid_o` is 1 for exactly one cycle. `rx_bit_o` is 1 if the sample was high and 0 if it was low.
- R5: If `tx_valid_i` is 1 and `tx_bit_i` is 0 at the slot-start edge, `pull_o` is 1 from the next cycle until the edge PULL cycles after the first low sample. That is PULL_STD-FLT_STD+1 cycles at standard speed and PULL_OD cycles at overdrive.
- R6: If `tx_bit_i` is 1, or `tx_valid_i` is 0, at the slot-start edge, `pull_o` stays 0 for the whole slot, so the host reads a 1.
- R7: `tx_take_o` pulses for one cycle after the slot-start edge exactly when `tx_valid_i` was 1 there. Otherwise it stays 0.
- R8: After the pulldown period the engine waits for a high sample. A line held low beyond it yields exactly one received bit and no new slot.
- R9: For the HOLD-1 clock edges following the first high sample (HOLD_STD or HOLD_OD of the finished slot), low samples are ignored.
- R10: A low that is still present, or newly present, once the hold-off window has ended starts a new slot. The window is timed from the first low sample seen after it.
- R11: `od_sel_i` (0 = standard, 1 = overdrive) is taken only in the idle state. A change during a slot does not alter that slot's sampling point, pulldown length or hold-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| line_i | input | 1 | Synchronized bus level, 1 = high |
| od_sel_i | input | 1 | Speed select: 0 standard, 1 overdrive |
| tx_valid_i | input | 1 | A bit to send is ready |
| tx_bit_i | input | 1 | Value of the bit to send |
| pull_o | output | 1 | Pulldown enable for the open-drain pad |
| tx_take_o | output | 1 | One-cycle pulse: the offered bit was used in this slot |
| rx_valid_o | output | 1 | One-cycle strobe: a bit was sampled |
| rx_bit_o | output | 1 | Sampled bit value |

## Verification
The bench drives lows of FLT_STD-1 and FLT_STD samples. An off-by-one filter would either start a slot on noise or drop a minimum-width write. It holds the line low past the pulldown period to catch a design that restarts a slot on the stuck low. It injects a one-cycle glitch inside the hold-off window, which a design with no hold-off would decode as an extra bit. It also applies a long low that straddles the window, which a design that discards such a low would miss. It flips the speed select two cycles into a slot. A design that switched speed at once would sample early and report a 0 instead of a 1. It checks the exact pulldown length at both speeds.

// File: rtl/sws_pkg.sv
package sws_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    SWS_IDLE = 3'd0,
    SWS_FILT = 3'd1,
    SWS_ACT  = 3'd2,
    SWS_RISE = 3'd3,
    SWS_HOLD = 3'd4
  } sws_state_e;
endpackage

// File: rtl/sws_timing.sv
// Picks the cycle limits of the current speed set.
module sws_timing #(
  parameter int CW       = 16,
  parameter int FLT_STD  = 63,
  parameter int SAMP_STD = 3750,
  parameter int PULL_STD = 5000,
  parameter int HOLD_STD = 625,
  parameter int SAMP_OD  = 375,
  parameter int PULL_OD  = 500,
  parameter int HOLD_OD  = 250
) (
  input  logic          od_i,
  output logic [CW-1:0] filt_lim_o,
  output logic [CW-1:0] samp_lim_o,
  output logic [CW-1:0] pull_lim_o,
  output logic [CW-1:0] hold_lim_o
);
  localparam logic [CW-1:0] L_FLT_STD  = CW'(FLT_STD);
  localparam logic [CW-1:0] L_FLT_OD   = CW'(1);
  localparam logic [CW-1:0] L_SAMP_STD = CW'(SAMP_STD);
  localparam logic [CW-1:0] L_SAMP_OD  = CW'(SAMP_OD);
  localparam logic [CW-1:0] L_PULL_STD = CW'(PULL_STD);
  localparam logic [CW-1:0] L_PULL_OD  = CW'(PULL_OD);
  localparam logic [CW-1:0] L_HOLD_STD = CW'(HOLD_STD);
  localparam logic [CW-1:0] L_HOLD_OD  = CW'(HOLD_OD);

  always_comb begin
    if (od_i) begin
      filt_lim_o = L_FLT_OD;
      samp_lim_o = L_SAMP_OD;
      pull_lim_o = L_PULL_OD;
      hold_lim_o = L_HOLD_OD;
    end else begin
      filt_lim_o = L_FLT_STD;
      samp_lim_o = L_SAMP_STD;
      pull_lim_o = L_PULL_STD;
      hold_lim_o = L_HOLD_STD;
    end
  end
endmodule

// File: rtl/sws_seq.sv
// Slot sequencer: edge filter, slot timer, rise wait and hold-off.
module sws_seq
  import sws_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          od_sel_i,
  input  logic [CW-1:0] filt_lim_i,
  input  logic [CW-1:0] samp_lim_i,
  input  logic [CW-1:0] pull_lim_i,
  input  logic [CW-1:0] hold_lim_i,
  output logic          spd_o,
  output logic          start_o,
  output logic          samp_o,
  output logic          pull_end_o,
  output sws_state_e    state_o,
  output logic          od_q_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  sws_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          od_q, od_d, od_en;

  // speed of the slot in progress; the live input only while idle
  assign spd_o   = (state_q == SWS_IDLE) ? od_sel_i : od_q;
  assign state_o = state_q;
  assign od_q_o  = od_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    od_d       = od_q;
    od_en      = 1'b0;
    start_o    = 1'b0;
    samp_o     = 1'b0;
    pull_end_o = 1'b0;
    unique case (state_q)
      SWS_IDLE: begin
        od_d  = od_sel_i;
        od_en = 1'b1;
        if (!line_i) begin
          cnt_d  = ONE;
          cnt_en = 1'b1;
          if (filt_lim_i == ONE) begin
            state_d = SWS_ACT;
            start_o = 1'b1;
          end else begin
            state_d = SWS_FILT;
          end
        end
      end
      SWS_FILT: begin
        if (line_i) begin
          state_d = SWS_IDLE;
        end else begin
          cnt_d  = cnt_q + ONE;
          cnt_en = 1'b1;
          if (cnt_q == filt_lim_i - ONE) begin
            state_d = SWS_ACT;
            start_o = 1'b1;
          end
        end
      end
      SWS_ACT: begin
        if (cnt_q == samp_lim_i) samp_o = 1'b1;
        if (cnt_q == pull_lim_i) begin
          pull_end_o = 1'b1;
          state_d    = SWS_RISE;
        end else begin
          cnt_d  = cnt_q + ONE;
          cnt_en = 1'b1;
        end
      end
      SWS_RISE: begin
        if (line_i) begin
          state_d = SWS_HOLD;
          cnt_d   = ONE;
          cnt_en  = 1'b1;
        end
      end
      SWS_HOLD: begin
        if (cnt_q >= hold_lim_i - ONE) begin
          state_d = SWS_IDLE;
        end else begin
          cnt_d  = cnt_q + ONE;
          cnt_en = 1'b1;
        end
      end
      default: state_d = SWS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SWS_IDLE;
      cnt_q   <= '0;
      od_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (od_en)  od_q  <= od_d;
    end
  end
endmodule

// File: rtl/sws_bitio.sv
// Bit datapath: pulldown, take pulse and received bit registers.
module sws_bitio (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic start_i,
  input  logic samp_i,
  input  logic pull_end_i,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic tx_take_o,
  output logic rx_valid_o,
  output logic rx_bit_o
);
  logic pull_q, pull_d, pull_en;
  logic take_q, take_d;
  logic rxv_q, rxv_d;
  logic rxb_q, rxb_en;

  always_comb begin
    pull_en = start_i | pull_end_i;
    pull_d  = start_i ? (tx_valid_i & ~tx_bit_i) : 1'b0;
    take_d  = start_i & tx_valid_i;
    rxv_d   = samp_i;
    rxb_en  = samp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
      take_q <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= 1'b0;
    end else begin
      if (pull_en) pull_q <= pull_d;
      take_q <= take_d;
      rxv_q  <= rxv_d;
      if (rxb_en) rxb_q <= line_i;
    end
  end

  assign pull_o     = pull_q;
  assign tx_take_o  = take_q;
  assign rx_valid_o = rxv_q;
  assign rx_bit_o   = rxb_q;
endmodule

// File: rtl/sw_slot_engine.sv
// Top: single-wire slave time-slot engine.
module sw_slot_engine
  import sws_pkg::*;
#(
  parameter int CW       = 16,
  parameter int FLT_STD  = 63,
  parameter int SAMP_STD = 3750,
  parameter int PULL_STD = 5000,
  parameter int HOLD_STD = 625,
  parameter int SAMP_OD  = 375,
  parameter int PULL_OD  = 500,
  parameter int HOLD_OD  = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic od_sel_i,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic tx_take_o,
  output logic rx_valid_o,
  output logic rx_bit_o
);
  logic [CW-1:0] filt_lim, samp_lim, pull_lim, hold_lim;
  logic          spd, slot_start, samp_hit, pull_end;
  sws_state_e    seq_state;
  logic          seq_od;

  sws_timing #(
    .CW(CW), .FLT_STD(FLT_STD), .SAMP_STD(SAMP_STD), .PULL_STD(PULL_STD),
    .HOLD_STD(HOLD_STD), .SAMP_OD(SAMP_OD), .PULL_OD(PULL_OD), .HOLD_OD(HOLD_OD)
  ) u_timing (
    .od_i(spd), .filt_lim_o(filt_lim), .samp_lim_o(samp_lim),
    .pull_lim_o(pull_lim), .hold_lim_o(hold_lim)
  );

  sws_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .od_sel_i(od_sel_i),
    .filt_lim_i(filt_lim), .samp_lim_i(samp_lim), .pull_lim_i(pull_lim),
    .hold_lim_i(hold_lim), .spd_o(spd), .start_o(slot_start),
    .samp_o(samp_hit), .pull_end_o(pull_end), .state_o(seq_state),
    .od_q_o(seq_od)
  );

  sws_bitio u_bitio (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .start_i(slot_start),
    .samp_i(samp_hit), .pull_end_i(pull_end), .tx_valid_i(tx_valid_i),
    .tx_bit_i(tx_bit_i), .pull_o(pull_o), .tx_take_o(tx_take_o),
    .rx_valid_o(rx_valid_o), .rx_bit_o(rx_bit_o)
  );
endmodule

// File: rtl/sws_chk.sv
// Property checker attached to the engine.
module sws_chk
  import sws_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       line_i,
  input logic       tx_valid_i,
  input logic       tx_bit_i,
  input logic       pull_o,
  input logic       rx_valid_o,
  input logic       tx_take_o,
  input sws_state_e st,
  input logic       od_q
);
  a_r2_start_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |-> $past(!line_i));

  a_r4_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r7_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |=> !tx_take_o);

  a_r6_pull_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_o) |-> $past(tx_valid_i && !tx_bit_i));

  a_r5_pull_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |-> (st == SWS_ACT));

  a_r8_rise_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SWS_RISE) |=> !tx_take_o);

  a_r11_speed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SWS_IDLE) |=> $stable(od_q));
endmodule

bind sw_slot_engine sws_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_i(line_i), .tx_valid_i(tx_valid_i),
  .tx_bit_i(tx_bit_i), .pull_o(pull_o), .rx_valid_o(rx_valid_o),
  .tx_take_o(tx_take_o), .st(seq_state), .od_q(seq_od)
);

// File: tb/test_sw_slot_engine.sv
module test_sw_slot_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int P_FLT = 4, P_SS = 20, P_PS = 30, P_HS = 6;
  localparam int P_SO = 6, P_PO = 9, P_HO = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0, od_sel = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1;
  logic pull, take, rxv, rxb;
  wire  line = !(host_low || pull);

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit e_pull = 0, e_take = 0, e_rxv = 0, e_rxb = 0;
  int since = 0, guard = 0;
  bit want_rise = 0, m_od = 0;

  // scenario observations
  bit q[$];
  int pull_cnt = 0, take_cnt = 0;

  always #4 clk = ~clk;

  sw_slot_engine #(
    .CW(16), .FLT_STD(P_FLT), .SAMP_STD(P_SS), .PULL_STD(P_PS), .HOLD_STD(P_HS),
    .SAMP_OD(P_SO), .PULL_OD(P_PO), .HOLD_OD(P_HO)
  ) i_sw_slot_engine (
    .clk(clk), .rst_n(rst_n), .line_i(line), .od_sel_i(od_sel),
    .tx_valid_i(tx_valid), .tx_bit_i(tx_bit), .pull_o(pull),
    .tx_take_o(take), .rx_valid_o(rxv), .rx_bit_o(rxb)
  );

  function automatic int f_fw(bit od);   return od ? 1 : P_FLT; endfunction
  function automatic int f_samp(bit od); return od ? P_SO : P_SS; endfunction
  function automatic int f_pull(bit od); return od ? P_PO : P_PS; endfunction
  function automatic int f_hold(bit od); return od ? P_HO : P_HS; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_start();
    e_take = tx_valid;
    e_pull = tx_valid && !tx_bit;
  endtask

  // compare, then predict the next rising edge (all inputs settled)
  always @(negedge clk) begin
    #1;
    chk(pull === e_pull, "R5 pull_o", int'(pull), int'(e_pull));
    chk(rxv === e_rxv, "R4 rx_valid_o", int'(rxv), int'(e_rxv));
    if (e_rxv) chk(rxb === e_rxb, "R4 rx_bit_o", int'(rxb), int'(e_rxb));
    chk(take === e_take, "R7 tx_take_o", int'(take), int'(e_take));
    if (rxv === 1'b1) q.push_back(rxb);
    if (pull === 1'b1) pull_cnt++;
    if (take === 1'b1) take_cnt++;
    if (!rst_n) begin
      e_pull = 0; e_take = 0; e_rxv = 0; e_rxb = 0;
      since = 0; guard = 0; want_rise = 0; m_od = 0;
    end else begin
      e_rxv = 0;
      e_take = 0;
      if (guard > 0) begin
        guard--;
      end else if (want_rise) begin
        if (line) begin
          guard = f_hold(m_od) - 1;
          want_rise = 0;
        end
      end else if (since == 0) begin
        m_od = od_sel;
        if (!line) begin
          since = 1;
          if (f_fw(m_od) == 1) model_start();
        end
      end else if (since < f_fw(m_od)) begin
        if (line) since = 0;
        else begin
          since++;
          if (since == f_fw(m_od)) model_start();
        end
      end else begin
        if (since == f_samp(m_od)) begin
          e_rxv = 1;
          e_rxb = line;
        end
        if (since == f_pull(m_od)) begin
          e_pull = 0;
          want_rise = 1;
          since = 0;
        end else since++;
      end
    end
  end

  task automatic clr();
    q.delete();
    pull_cnt = 0;
    take_cnt = 0;
  endtask

  task automatic slot(int low_n, int tail, bit txv, bit txb);
    clr();
    tx_valid = txv;
    tx_bit = txb;
    host_low = 1'b1;
    repeat (low_n) @(negedge clk);
    host_low = 1'b0;
    repeat (tail) @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic expect_res(string req, int n_rx, bit last, int n_pull, int n_take);
    #2;
    chk(q.size() == n_rx, {req, " bit count"}, q.size(), n_rx);
    if (n_rx > 0 && q.size() > 0) chk(q[$] == last, {req, " bit value"}, int'(q[$]), int'(last));
    chk(pull_cnt == n_pull, {req, " pulldown cycles"}, pull_cnt, n_pull);
    chk(take_cnt == n_take, {req, " takes"}, take_cnt, n_take);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(pull === 1'b0 && rxv === 1'b0 && take === 1'b0, "R1 in reset", int'({pull, rxv, take}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #2;
    chk(pull === 1'b0 && rxv === 1'b0 && take === 1'b0, "R1 idle", int'({pull, rxv, take}), 0);
    @(negedge clk);

    slot(6, 45, 0, 1);  expect_res("R4 write one", 1, 1, 0, 0);
    @(negedge clk);
    slot(25, 45, 0, 1); expect_res("R4 write zero", 1, 0, 0, 0);
    @(negedge clk);
    slot(3, 10, 1, 0);  expect_res("R2 short low rejected", 0, 0, 0, 0);
    @(negedge clk);
    slot(4, 45, 0, 1);  expect_res("R2 minimum width", 1, 1, 0, 0);
    @(negedge clk);
    slot(45, 45, 0, 1); expect_res("R8 stuck low", 1, 0, 0, 0);
    @(negedge clk);
    slot(6, 45, 1, 0);  expect_res("R5 read zero std", 1, 0, P_PS - P_FLT + 1, 1);
    @(negedge clk);
    slot(6, 45, 1, 1);  expect_res("R6 read one", 1, 1, 0, 1);
    @(negedge clk);
    slot(6, 45, 0, 0);  expect_res("R7 nothing ready", 1, 1, 0, 0);

    // R9: one-cycle glitch just after the rise
    @(negedge clk);
    clr();
    host_low = 1'b1;
    repeat (40) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
    host_low = 1'b1;
    @(negedge clk);
    host_low = 1'b0;
    repeat (45) @(negedge clk);
    expect_res("R9 hold-off glitch", 1, 0, 0, 0);

    // R10: low starting in the window and lasting past it
    @(negedge clk);
    clr();
    host_low = 1'b1;
    repeat (40) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
    host_low = 1'b1;
    repeat (30) @(negedge clk);
    host_low = 1'b0;
    repeat (45) @(negedge clk);
    expect_res("R10 late low", 2, 0, 0, 0);

    // R11: speed flips two cycles into a standard slot
    @(negedge clk);
    clr();
    host_low = 1'b1;
    repeat (2) @(negedge clk);
    od_sel = 1'b1;
    repeat (8) @(negedge clk);
    host_low = 1'b0;
    repeat (45) @(negedge clk);
    expect_res("R11 speed held", 1, 1, 0, 0);

    // overdrive slots
    @(negedge clk);
    repeat (3) @(negedge clk);
    slot(1, 20, 0, 1);  expect_res("R3 single low sample", 1, 1, 0, 0);
    @(negedge clk);
    slot(8, 20, 0, 1);  expect_res("R4 write zero od", 1, 0, 0, 0);
    @(negedge clk);
    slot(1, 20, 1, 0);  expect_res("R5 read zero od", 1, 0, P_PO, 1);
    @(negedge clk);
    od_sel = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule